// File: doc/BRIEF.md
# Master Clock Loss Supervisor

This block supervises a master reference clock. It samples that clock with a faster, independent free-running clock and measures the fraction of each measurement slice during which the master clock is high. When every slice over a complete observation window falls below 30% high time, the block declares the master clock lost. It then puts the rest of the chip into a power-down state: the receive and transmit paths are disabled, the line-side drivers are released to high impedance, and the system-side pins take a defined safe state.

The recovery path has hysteresis. A full window of healthy slices must pass before the block leaves loss. When it does, it first issues a device reset pulse of fixed length, and it drops the loss flag in the same cycle that pulse ends. After an asynchronous reset the block assumes that no clock is present. It therefore starts in loss, and it leaves through the same recovery path once the first healthy window has completed.

The sampling clock must run at least four times faster than the fastest master clock. That master clock can be N times 1.544 MHz or N times 2.048 MHz, with N from 1 to 8. The window length is a parameter counted in sampling cycles, and it must be a whole multiple of the slice length.

Top module: `mclk_loss_supervisor`

## Requirements
- R1: While the asynchronous reset is asserted, and on the cycles directly after its release, `loss_o` is 1, every power-down control is in its loss state, and `dev_rst_o` is 0.
- R2: `loss_o` rises only after WINDOW_CYCLES/SLICE_CYCLES consecutive slices have all been below the threshold. It never rises earlier than WINDOW_CYCLES minus SLICE_CYCLES sampling cycles after the master clock degrades.
- R3: While the block is running, any slice at or above the threshold restarts the loss window. Bad stretches that are shorter than a window and separated by healthy stretches never raise `loss_o`.
- R4: Leaving loss requires WINDOW_CYCLES/SLICE_CYCLES consecutive healthy slices. A healthy stretch that is shorter than a window, followed by a bad clock, produces no reset pulse and keeps `loss_o` at 1.
- R5: On recovery, `dev_rst_o` is high for exactly PULSE_CYCLES consecutive cycles, only while `loss_o` is 1. `loss_o` falls in the same cycle that `dev_rst_o` falls.
- R6: `rx_en_o` and `tx_en_o` are 0 while `loss_o` is 1, and they are 1 otherwise.
- R7: `line_oe_o` is 0 (line pins at high impedance) while `loss_o` is 1, and it is 1 otherwise.
- R8: While `loss_o` is 1, `rhz_i`=1 gives `rsys_oe_o`=0 and `rsys_low_o`=0, and `rhz_i`=0 gives `rsys_oe_o`=1 and `rsys_low_o`=1 (pins driven low). While `loss_o` is 0, the outputs are `rsys_oe_o`=1 and `rsys_low_o`=0.
- R9: While `loss_o` is 1, `tsys_oe_o`=0 and `tsys_in_en_o`=0, so the transmit system input is ignored. Both are 1 otherwise.
- R10: A slice counts as healthy when (high samples × 10) ≥ 3 × SLICE_CYCLES, which means a high time of exactly 30% is healthy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running sampling clock |
| arst_n_i | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock being supervised (asynchronous) |
| rhz_i | input | 1 | During loss: 1 = receive system pins high impedance, 0 = driven low |
| loss_o | output | 1 | Master clock loss flag |
| rx_en_o | output | 1 | Receive path enable |
| tx_en_o | output | 1 | Transmit path enable |
| line_oe_o | output | 1 | Line interface output enable |
| rsys_oe_o | output | 1 | Receive system interface output enable |
| rsys_low_o | output | 1 | Force receive system outputs low |
| tsys_oe_o | output | 1 | Transmit system interface output enable |
| tsys_in_en_o | output | 1 | Transmit system interface input accept |
| dev_rst_o | output | 1 | Automatic device reset pulse issued on recovery |

## Verification
The bench builds the block with SLICE_CYCLES=10, WINDOW_CYCLES=40 and PULSE_CYCLES=4. A full loss or recovery window is then only four slices long, so every transition is reached within a few dozen cycles. The bench sweeps master clock periods of 2, 5 and 10 sampling cycles, each with every possible high time. Because each period divides the slice evenly, the high count per slice is exact, and the bench can compute the 30% verdict arithmetically at both edges of the threshold. It also drives bad stretches shorter than a window interleaved with healthy ones, and healthy stretches shorter than a window during loss, to reach the window restart and the recovery hysteresis.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Supervisor state: loss (power-down), reset pulse, normal running
  typedef enum logic [1:0] {
    ST_LOSS  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RUN   = 2'd2
  } mcs_state_e;

  // Duty threshold expressed as a ratio NUM/DEN (30 %)
  localparam int unsigned DUTY_NUM = 3;
  localparam int unsigned DUTY_DEN = 10;

endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_n = d_i;
    end else begin : g_many
      always_comb chain_n = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_n;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mcs_duty_meter.sv
module mcs_duty_meter
  import mcs_pkg::*;
#(
  parameter int unsigned SLICE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sample_i,
  output logic slice_done_o,
  output logic slice_ok_o
);

  localparam int unsigned CW  = (SLICE_CYCLES > 1) ? $clog2(SLICE_CYCLES) : 1;
  localparam int unsigned HW  = $clog2(SLICE_CYCLES + 1);
  localparam int unsigned PW  = HW + 4;
  localparam logic [CW-1:0] CNT_LAST = CW'(SLICE_CYCLES - 1);
  localparam logic [PW-1:0] THRESH   = PW'(DUTY_NUM * SLICE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [HW-1:0] hi_q, hi_n;
  logic          done_q, done_n;
  logic          ok_q, ok_n;
  logic [HW-1:0] hi_acc;
  logic [PW-1:0] hi_scaled;
  logic          slice_end;

  always_comb begin
    slice_end = (cnt_q == CNT_LAST);
    hi_acc    = hi_q + HW'(sample_i);
    hi_scaled = PW'(hi_acc) * PW'(DUTY_DEN);
    cnt_n     = cnt_q + CW'(1);
    hi_n      = hi_acc;
    done_n    = 1'b0;
    ok_n      = ok_q;
    if (slice_end) begin
      cnt_n  = '0;
      hi_n   = '0;
      done_n = 1'b1;
      ok_n   = (hi_scaled >= THRESH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      hi_q   <= hi_n;
      done_q <= done_n;
      ok_q   <= ok_n;
    end
  end

  assign slice_done_o = done_q;
  assign slice_ok_o   = ok_q;

  // R10: high count never exceeds the samples taken in the slice so far
  p_hi_bounded_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    HW'(hi_q) <= HW'(cnt_q));

  // R10: slice verdicts arrive as isolated one-cycle strobes
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (SLICE_CYCLES > 1 && done_q) |=> !done_q);

endmodule

// File: rtl/mcs_window_fsm.sv
module mcs_window_fsm
  import mcs_pkg::*;
#(
  parameter int unsigned WIN_SLICES   = 16,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic slice_done_i,
  input  logic slice_ok_i,
  output logic loss_o,
  output logic dev_rst_o
);

  localparam int unsigned RW = $clog2(WIN_SLICES + 1);
  localparam int unsigned PCW = $clog2(PULSE_CYCLES + 1);
  localparam logic [RW-1:0]  RUN_LAST   = RW'(WIN_SLICES - 1);
  localparam logic [PCW-1:0] PULSE_LAST = PCW'(PULSE_CYCLES - 1);

  mcs_state_e     state_q, state_n;
  logic [RW-1:0]  run_q, run_n;
  logic [PCW-1:0] pcnt_q, pcnt_n;
  logic           bad_slice, good_slice;

  always_comb begin
    bad_slice  = slice_done_i && !slice_ok_i;
    good_slice = slice_done_i &&  slice_ok_i;
    state_n    = state_q;
    run_n      = run_q;
    pcnt_n     = pcnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (bad_slice) begin
          if (run_q == RUN_LAST) begin
            state_n = ST_LOSS;
            run_n   = '0;
          end else begin
            run_n = run_q + RW'(1);
          end
        end else if (good_slice) begin
          run_n = '0;
        end
      end
      ST_LOSS: begin
        if (good_slice) begin
          if (run_q == RUN_LAST) begin
            state_n = ST_PULSE;
            run_n   = '0;
            pcnt_n  = '0;
          end else begin
            run_n = run_q + RW'(1);
          end
        end else if (bad_slice) begin
          run_n = '0;
        end
      end
      ST_PULSE: begin
        if (pcnt_q == PULSE_LAST) begin
          state_n = ST_RUN;
          run_n   = '0;
        end else begin
          pcnt_n = pcnt_q + PCW'(1);
        end
      end
      default: begin
        state_n = ST_LOSS;
        run_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_LOSS;
      run_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      run_q   <= run_n;
      pcnt_q  <= pcnt_n;
    end
  end

  assign loss_o    = (state_q != ST_RUN);
  assign dev_rst_o = (state_q == ST_PULSE);

  // R2: running state is left only on a below-threshold slice
  p_loss_needs_bad_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_RUN && !bad_slice) |=> state_q == ST_RUN);

  // R3: a healthy slice while running empties the loss window
  p_window_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_RUN && good_slice) |=> (run_q == '0));

  // R4: loss is left only on a healthy slice
  p_recover_needs_good_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_LOSS && !good_slice) |=> state_q == ST_LOSS);

endmodule

// File: rtl/mcs_pd_ctrl.sv
module mcs_pd_ctrl (
  input  logic loss_i,
  input  logic rhz_i,
  output logic rx_en_o,
  output logic tx_en_o,
  output logic line_oe_o,
  output logic rsys_oe_o,
  output logic rsys_low_o,
  output logic tsys_oe_o,
  output logic tsys_in_en_o
);

  always_comb begin
    rx_en_o      = !loss_i;
    tx_en_o      = !loss_i;
    line_oe_o    = !loss_i;
    tsys_oe_o    = !loss_i;
    tsys_in_en_o = !loss_i;
    rsys_oe_o    = !(loss_i && rhz_i);
    rsys_low_o   = loss_i && !rhz_i;
  end

endmodule

// File: rtl/mclk_loss_supervisor.sv
module mclk_loss_supervisor #(
  parameter int unsigned SLICE_CYCLES  = 64,
  parameter int unsigned WINDOW_CYCLES = 1024,
  parameter int unsigned PULSE_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic mclk_i,
  input  logic rhz_i,
  output logic loss_o,
  output logic rx_en_o,
  output logic tx_en_o,
  output logic line_oe_o,
  output logic rsys_oe_o,
  output logic rsys_low_o,
  output logic tsys_oe_o,
  output logic tsys_in_en_o,
  output logic dev_rst_o
);

  localparam int unsigned WIN_SLICES = WINDOW_CYCLES / SLICE_CYCLES;

  logic rst_n;
  logic mclk_s;
  logic slice_done;
  logic slice_ok;

  // Reset: asserted asynchronously, released on the sampling clock
  mcs_sync #(.STAGES(2)) i_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (arst_n_i),
    .d_i     (1'b1),
    .q_o     (rst_n)
  );

  mcs_sync #(.STAGES(SYNC_STAGES)) i_mclk_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .d_i     (mclk_i),
    .q_o     (mclk_s)
  );

  mcs_duty_meter #(.SLICE_CYCLES(SLICE_CYCLES)) i_meter (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .sample_i     (mclk_s),
    .slice_done_o (slice_done),
    .slice_ok_o   (slice_ok)
  );

  mcs_window_fsm #(
    .WIN_SLICES   (WIN_SLICES),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .slice_done_i (slice_done),
    .slice_ok_i   (slice_ok),
    .loss_o       (loss_o),
    .dev_rst_o    (dev_rst_o)
  );

  mcs_pd_ctrl i_pd (
    .loss_i       (loss_o),
    .rhz_i        (rhz_i),
    .rx_en_o      (rx_en_o),
    .tx_en_o      (tx_en_o),
    .line_oe_o    (line_oe_o),
    .rsys_oe_o    (rsys_oe_o),
    .rsys_low_o   (rsys_low_o),
    .tsys_oe_o    (tsys_oe_o),
    .tsys_in_en_o (tsys_in_en_o)
  );

  // R5: the reset pulse lies entirely inside the loss interval
  p_rst_inside_loss_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    dev_rst_o |-> loss_o);

  // R5: loss clears exactly when the reset pulse ends
  p_loss_clears_with_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(loss_o) |-> $fell(dev_rst_o));

  // R6: paths are off during loss
  p_paths_off_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    loss_o |-> (!rx_en_o && !tx_en_o));

  // R7: line drivers released during loss
  p_line_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    loss_o |-> !line_oe_o);

  // R8: receive system pins follow the high-impedance select during loss
  p_rsys_state_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    loss_o |-> (rhz_i ? !rsys_oe_o : (rsys_oe_o && rsys_low_o)));

  // R9: transmit system side closed during loss
  p_tsys_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    loss_o |-> (!tsys_oe_o && !tsys_in_en_o));

endmodule

// File: tb/test_mclk_loss_supervisor.sv
module test_mclk_loss_supervisor;

  localparam int SL  = 10;
  localparam int WIN = 40;
  localparam int PUL = 4;

  logic clk;
  logic arst_n;
  logic mclk;
  logic rhz;
  logic loss, rx_en, tx_en, line_oe, rsys_oe, rsys_low, tsys_oe, tsys_in_en, dev_rst;

  int per;
  int hi;
  int checks;
  int failures;
  bit finished;

  mclk_loss_supervisor #(
    .SLICE_CYCLES  (SL),
    .WINDOW_CYCLES (WIN),
    .PULSE_CYCLES  (PUL)
  ) i_mclk_loss_supervisor (
    .clk_i        (clk),
    .arst_n_i     (arst_n),
    .mclk_i       (mclk),
    .rhz_i        (rhz),
    .loss_o       (loss),
    .rx_en_o      (rx_en),
    .tx_en_o      (tx_en),
    .line_oe_o    (line_oe),
    .rsys_oe_o    (rsys_oe),
    .rsys_low_o   (rsys_low),
    .tsys_oe_o    (tsys_oe),
    .tsys_in_en_o (tsys_in_en),
    .dev_rst_o    (dev_rst)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // Master clock generator: period per, high for the first hi cycles
  initial begin
    int ph;
    ph   = 0;
    mclk = 1'b0;
    forever begin
      @(negedge clk);
      ph   = (ph + 1 >= per) ? 0 : ph + 1;
      mclk = (ph < hi);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_pd(input string tag);
    rhz = 1'b1;
    step();
    check(!rx_en && !tx_en, "R6", {rx_en, tx_en}, 0);
    check(!line_oe, "R7", line_oe, 0);
    check(!rsys_oe && !rsys_low, "R8 rhz=1", {rsys_oe, rsys_low}, 0);
    check(!tsys_oe && !tsys_in_en, "R9", {tsys_oe, tsys_in_en}, 0);
    rhz = 1'b0;
    step();
    check(rsys_oe && rsys_low, "R8 rhz=0", {rsys_oe, rsys_low}, 3);
    rhz = 1'b1;
  endtask

  task automatic check_run();
    check(rx_en && tx_en, "R6", {rx_en, tx_en}, 3);
    check(line_oe, "R7", line_oe, 1);
    check(rsys_oe && !rsys_low, "R8", {rsys_oe, rsys_low}, 2);
    check(tsys_oe && tsys_in_en, "R9", {tsys_oe, tsys_in_en}, 3);
  endtask

  task automatic recover();
    int n;
    int len;
    int lowseen;
    per = 2; hi = 1;
    n = 0;
    while (!dev_rst && n < 200) begin
      step();
      n++;
    end
    check(dev_rst && n >= WIN - SL && n <= WIN + 2*SL + 4, "R4 recovery delay", n, WIN);
    len = 0;
    lowseen = 0;
    while (dev_rst && len < 100) begin
      if (!loss) lowseen++;
      step();
      len++;
    end
    check(len == PUL, "R5 pulse length", len, PUL);
    check(lowseen == 0, "R5 loss held during pulse", lowseen, 0);
    check(loss == 0, "R5 loss clear at pulse end", loss, 0);
  endtask

  initial begin
    int periods[3];
    int rose;
    int exp_bad;
    int cnt;
    periods = '{2, 5, 10};
    checks = 0; failures = 0; finished = 0;
    per = 2; hi = 1;
    rhz = 1'b1;
    arst_n = 1'b0;
    repeat (3) step();
    check(loss && !dev_rst, "R1 in reset", {loss, dev_rst}, 2);
    arst_n = 1'b1;
    step();
    check(loss && !dev_rst, "R1 after release", {loss, dev_rst}, 2);
    check_pd("R1");

    recover();
    check_run();

    // Sweep over periods and every high time
    foreach (periods[k]) begin
      for (int h = 0; h <= periods[k]; h++) begin
        per = periods[k]; hi = h;
        rose = -1;
        for (int i = 0; i < WIN + 3*SL + 10; i++) begin
          step();
          if (loss && rose < 0) rose = i + 1;
        end
        exp_bad = ((h * (SL / periods[k])) * 10 < 3 * SL) ? 1 : 0;
        check((rose >= 0) == (exp_bad == 1), "R10 threshold verdict", (rose >= 0), exp_bad);
        if (rose >= 0) begin
          check(rose >= WIN - SL, "R2 loss delay", rose, WIN);
          check_pd("R6-R9");
          recover();
          check_run();
        end
      end
    end

    // R3: short bad stretches between healthy stretches never cause loss
    per = 2;
    cnt = 0;
    for (int r = 0; r < 6; r++) begin
      hi = 0;
      for (int i = 0; i < 15; i++) begin step(); if (loss) cnt++; end
      hi = 1;
      for (int i = 0; i < 25; i++) begin step(); if (loss) cnt++; end
    end
    check(cnt == 0, "R3 window restart", cnt, 0);

    // R4: short healthy stretch during loss does not recover
    hi = 0;
    cnt = 0;
    while (!loss && cnt < 200) begin step(); cnt++; end
    check(loss == 1, "R2 loss on stuck-low clock", loss, 1);
    hi = 1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin step(); if (dev_rst || !loss) cnt++; end
    hi = 0;
    for (int i = 0; i < 80; i++) begin step(); if (dev_rst || !loss) cnt++; end
    check(cnt == 0, "R4 hysteresis", cnt, 0);
    recover();
    check_run();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule